// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch Matrix

This block is a seventeen-by-seventeen crosspoint switch. Each output copies exactly one chosen input, and one input may feed any number of outputs at the same time. The data path is purely combinational and one bit wide per port. It needs no clock, so any rate, phase or bit pattern passes through unchanged.

Routing is set through a small synchronous register port. Software writes a 5-bit input index for each output into a staging register, in any order. These staged values have no effect on the data path until a commit write arrives. The commit copies every staged value into the live selection registers on one clock edge, so a complete new routing map appears at once.

Reads return the live selection, not the staged one. A selection index that names no input is refused, and the refusal is reported on a one-cycle error flag.

Top module: `xbar_matrix`

## Requirements
- R1: After reset, every live and staged selection for output N equals N, so `dout[N]` follows `din[N]`. `rdata` and `sel_err` are 0.
- R2: Each `dout[o]` equals `din[s]`, where s is the live selection of output o. This holds combinationally, with no clock edge in between.
- R3: One input may be selected by any number of outputs at the same time, and every output that selects it carries its value.
- R4: A write with `addr` 0..16 and `wdata` 0..16 changes only the staged selection for output `addr`. The live selection, the readback value and `dout` stay as they were until a commit.
- R5: A write to address 31 is a commit: on that edge every live selection takes its staged value. A staged write made in the cycle just before the commit is included in it.
- R6: A write with `addr` 0..16 and `wdata` 17..31 is refused. `sel_err` is 1 in the cycle after the write, and the staged selection is left unchanged. Any other write leaves `sel_err` at 0 in the following cycle.
- R7: When `rd_en` is high with `addr` 0..16, `rdata` holds that output's live selection in the next cycle. Addresses 17..31 read as 0.
- R8: Writes to addresses 17..30 change no selection and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 17 | Switch data inputs, one bit per input |
| dout | output | 17 | Switch data outputs, one bit per output |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address: 0..16 selects an output, 31 commits |
| wdata | input | 5 | Write data: the input index for the addressed output |
| rdata | output | 5 | Registered read data: the live selection |
| sel_err | output | 1 | One-cycle flag for a refused selection index |

## Verification
The assertions assume that reset is held for at least one clock edge before any strobe is used. They also assume that `addr` and `wdata` are settled whenever `wr_en` or `rd_en` is high. The stimulus meets both assumptions by changing every input only on the falling clock edge, after a reset phase of several cycles. The random mix of legal writes, refused indices, unmapped writes, commits and reads stays within those rules, so every assertion sees only well-defined strobes.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Decoded meaning of a register-port write
  typedef enum logic [1:0] {
    WOP_NONE   = 2'd0,
    WOP_STAGE  = 2'd1,
    WOP_COMMIT = 2'd2,
    WOP_REJECT = 2'd3
  } wr_op_e;

endpackage

// File: rtl/xbar_mux_tree.sv
module xbar_mux_tree #(
  parameter int N_PORTS = 17,
  parameter int SEL_W   = 5
) (
  input  logic [N_PORTS-1:0]            din,
  input  logic [N_PORTS-1:0][SEL_W-1:0] sel,
  output logic [N_PORTS-1:0]            dout
);

  // One N:1 selector per output, with no storage on the data path
  for (genvar o = 0; o < N_PORTS; o++) begin : g_out
    always_comb begin
      dout[o] = 1'b0;
      for (int i = 0; i < N_PORTS; i++) begin
        if (sel[o] == SEL_W'(i)) dout[o] = din[i];
      end
    end
  end

endmodule

// File: rtl/xbar_sel_bank.sv
module xbar_sel_bank #(
  parameter int N_PORTS = 17,
  parameter int SEL_W   = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_PORTS-1:0]            stage_we,
  input  logic [SEL_W-1:0]              stage_val,
  input  logic                          commit,
  output logic [N_PORTS-1:0][SEL_W-1:0] live_sel
);

  logic [N_PORTS-1:0][SEL_W-1:0] stage_q;
  logic [N_PORTS-1:0][SEL_W-1:0] live_q;

  for (genvar o = 0; o < N_PORTS; o++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[o] <= SEL_W'(o);
        live_q[o]  <= SEL_W'(o);
      end else begin
        if (stage_we[o]) stage_q[o] <= stage_val;
        if (commit)      live_q[o]  <= stage_q[o];
      end
    end
  end

  assign live_sel = live_q;

  // R5
  commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (live_q == $past(stage_q)));

  // R4
  live_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(live_q));

  // R6
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_we == '0) |=> $stable(stage_q));

endmodule

// File: rtl/xbar_regport.sv
module xbar_regport
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 17,
  parameter int SEL_W   = 5,
  parameter int ADDR_W  = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [SEL_W-1:0]              wdata,
  input  logic [N_PORTS-1:0][SEL_W-1:0] live_sel,
  output logic [N_PORTS-1:0]            stage_we,
  output logic [SEL_W-1:0]              stage_val,
  output logic                          commit,
  output logic [SEL_W-1:0]              rdata,
  output logic                          sel_err
);

  localparam int IDX_W = $clog2(N_PORTS);
  localparam logic [ADDR_W-1:0] LAST_OUT  = ADDR_W'(N_PORTS - 1);
  localparam logic [ADDR_W-1:0] CMT_ADDR  = {ADDR_W{1'b1}};
  localparam logic [SEL_W-1:0]  LAST_IN   = SEL_W'(N_PORTS - 1);

  logic    addr_is_out;
  logic    sel_ok;
  wr_op_e  wop;
  logic [SEL_W-1:0] rdata_q;
  logic             err_q;

  assign addr_is_out = (addr <= LAST_OUT);
  assign sel_ok      = (wdata <= LAST_IN);

  always_comb begin
    wop = WOP_NONE;
    if (wr_en) begin
      if (addr == CMT_ADDR)  wop = WOP_COMMIT;
      else if (addr_is_out)  wop = sel_ok ? WOP_STAGE : WOP_REJECT;
    end
  end

  for (genvar o = 0; o < N_PORTS; o++) begin : g_dec
    assign stage_we[o] = (wop == WOP_STAGE) && (addr == ADDR_W'(o));
  end

  assign stage_val = wdata;
  assign commit    = (wop == WOP_COMMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= (wop == WOP_REJECT);
      if (rd_en) rdata_q <= addr_is_out ? live_sel[addr[IDX_W-1:0]] : '0;
    end
  end

  assign rdata   = rdata_q;
  assign sel_err = err_q;

  // R6
  bad_sel_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_is_out && !sel_ok) |=> sel_err);

  // R8
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr_is_out && addr != CMT_ADDR) |=> (!sel_err && $stable(live_sel)));

  // R7
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr_is_out) |=> (rdata == '0));

  // R4
  stage_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stage_we));

endmodule

// File: rtl/xbar_matrix.sv
module xbar_matrix #(
  parameter int N_PORTS = 17,
  parameter int SEL_W   = 5,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PORTS-1:0] din,
  output logic [N_PORTS-1:0] dout,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SEL_W-1:0]   wdata,
  output logic [SEL_W-1:0]   rdata,
  output logic               sel_err
);

  logic [N_PORTS-1:0][SEL_W-1:0] live_sel;
  logic [N_PORTS-1:0]            stage_we;
  logic [SEL_W-1:0]              stage_val;
  logic                          commit;

  xbar_regport #(.N_PORTS(N_PORTS), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .live_sel(live_sel), .stage_we(stage_we),
    .stage_val(stage_val), .commit(commit), .rdata(rdata), .sel_err(sel_err)
  );

  xbar_sel_bank #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .rst(rst), .stage_we(stage_we), .stage_val(stage_val),
    .commit(commit), .live_sel(live_sel)
  );

  xbar_mux_tree #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_mux (
    .din(din), .sel(live_sel), .dout(dout)
  );

endmodule

// File: tb/sim_xbar_matrix.sv
`timescale 1ns/1ps
module sim_xbar_matrix;

  localparam int N = 17;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] din = '0;
  logic [N-1:0] dout;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [4:0]   addr  = '0;
  logic [4:0]   wdata = '0;
  logic [4:0]   rdata;
  logic         sel_err;

  int n_chk  = 0;
  int n_fail = 0;
  logic [4:0] stage_m [N];
  logic [4:0] live_m  [N];

  always #2.5 clk = ~clk;

  xbar_matrix u0 (
    .clk(clk), .rst(rst), .din(din), .dout(dout), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .sel_err(sel_err)
  );

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_dout(input logic [N-1:0] d);
    logic [N-1:0] r;
    for (int o = 0; o < N; o++) r[o] = d[live_m[o]];
    return r;
  endfunction

  task automatic check_dout(input string req, input logic [N-1:0] d);
    din = d;
    #0.5;
    check(dout == exp_dout(d), req, int'(dout), int'(exp_dout(d)));
  endtask

  task automatic do_write(input logic [4:0] a, input logic [4:0] d);
    string req;
    logic  exp_err;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    exp_err = (a <= 5'd16) && (d > 5'd16);
    if (a <= 5'd16) req = "R6";
    else if (a == 5'd31) req = "R5";
    else req = "R8";
    check(sel_err == exp_err, req, int'(sel_err), int'(exp_err));
    if (a <= 5'd16 && d <= 5'd16) stage_m[a] = d;
    if (a == 5'd31) for (int o = 0; o < N; o++) live_m[o] = stage_m[o];
  endtask

  task automatic do_read(input logic [4:0] a);
    logic [4:0] exp;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    exp = (a <= 5'd16) ? live_m[a] : 5'd0;
    check(rdata == exp, "R7", int'(rdata), int'(exp));
  endtask

  initial begin
    #(200000.0 * 5.0);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int o = 0; o < N; o++) begin
      stage_m[o] = 5'(o);
      live_m[o]  = 5'(o);
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(rdata == 5'd0, "R1", int'(rdata), 0);
    check(sel_err == 1'b0, "R1", int'(sel_err), 0);
    check_dout("R1", 17'h1A5C3);
    check_dout("R1", 17'h0F0F0);
    for (int o = 0; o < N; o++) do_read(5'(o));

    // R4 staged write is invisible before commit
    do_write(5'd3, 5'd9);
    do_read(5'd3);
    check_dout("R4", 17'h00200);
    check_dout("R4", 17'h1FDFF);

    // R5 commit applies it
    do_write(5'd31, 5'd0);
    do_read(5'd3);
    check_dout("R5", 17'h00200);
    check_dout("R2", 17'h1FDFF);

    // R3 fan-out: every output takes input 5
    for (int o = 0; o < N; o++) do_write(5'(o), 5'd5);
    do_write(5'd31, 5'd0);
    check_dout("R3", 17'h00020);
    check(dout == 17'h1FFFF, "R3", int'(dout), 17'h1FFFF);
    check_dout("R3", 17'h1FFDF);
    check(dout == 17'h00000, "R3", int'(dout), 0);

    // R5 write in the cycle right before commit is included
    @(negedge clk);
    wr_en = 1'b1; addr = 5'd7; wdata = 5'd16;
    @(negedge clk);
    addr = 5'd31;
    stage_m[7] = 5'd16;
    @(negedge clk);
    wr_en = 1'b0;
    for (int o = 0; o < N; o++) live_m[o] = stage_m[o];
    do_read(5'd7);
    check_dout("R5", 17'h10000);

    // R6 refused index leaves staging untouched
    do_write(5'd2, 5'd20);
    do_write(5'd2, 5'd31);
    do_write(5'd31, 5'd0);
    do_read(5'd2);

    // R8 unmapped writes, R7 unmapped reads
    do_write(5'd17, 5'd3);
    do_write(5'd30, 5'd25);
    do_write(5'd31, 5'd0);
    do_read(5'd17);
    do_read(5'd25);
    do_read(5'd31);
    check_dout("R8", 17'h0ABCD);

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1, 2: do_write(5'($urandom_range(0, 16)), 5'($urandom_range(0, 16)));
        3:       do_write(5'($urandom_range(0, 16)), 5'($urandom_range(17, 31)));
        4:       do_write(5'($urandom_range(17, 30)), 5'($urandom_range(0, 31)));
        5:       do_write(5'd31, 5'($urandom_range(0, 31)));
        6, 7:    do_read(5'($urandom_range(0, 31)));
        default: check_dout("R2", N'($urandom));
      endcase
    end

    finish_up();
  end

endmodule